// File: doc/BRIEF.md
# Advanced Load Address Table

This block supports data speculation. A load may be issued ahead of older stores whose addresses the scheduler could not tell apart from its own. When such an advanced load issues, it records its destination register tag and the 8-byte granule of its address in a small associative table. Every store that commits later is compared against every live entry, and each entry whose granule matches is dropped. When the program reaches the point where the load originally belonged, a check names the register. If the register's entry is still present, the hoisted value stands. If the entry is absent, the block raises a redirect so that execution branches to recovery code that reloads the value.

The table keeps at most one entry per register tag. A new advanced load to a register that already holds an entry overwrites that entry in place. When a new tag arrives and every slot is live, the slot allocated longest ago is given up. A later check on the displaced register then redirects, which costs time but is always correct. A check can optionally retire its entry when it succeeds.

Top module: `spec_load_table`

## Requirements
- R1: While reset is asserted, chk_resp_vld and chk_redirect are 0. After reset, every entry is empty, so any check redirects.
- R2: After an allocate for tag T, a check for T with no intervening matching store responds with chk_redirect = 0. A check for a tag that was never allocated responds with chk_redirect = 1.
- R3: A store whose granule equals an entry's granule removes that entry. A store to a different granule leaves the entry alone.
- R4: One store removes every entry whose granule matches, not only the first one found.
- R5: The granule is the address with its low 3 bits dropped (address bits ADDR_W-1..3). Any two addresses within the same aligned 8-byte block conflict, and addresses in adjacent blocks do not.
- R6: An allocate to a tag that already holds an entry reuses that entry. From then on, only the new address is snooped.
- R7: When all 16 entries are live, an allocate for a new tag displaces the entry whose most recent allocate is oldest. Re-allocating a tag counts as its most recent allocate.
- R8: An allocate for a new tag takes an empty entry, if one exists, in preference to displacing a live one.
- R9: When an allocate and a store to the same granule occur in the same cycle, the store is applied after the allocate, so the new entry is removed. With a different granule, the new entry survives.
- R10: A successful check with chk_clr = 1 removes its entry. With chk_clr = 0, the entry is kept.
- R11: A check sees the table as it stood before the cycle in which the check is presented. A store or allocate in that same cycle affects only later checks. chk_redirect is 1 only while chk_resp_vld is 1.
- R12: chk_resp_vld is 1 in exactly the cycle after each cycle with chk_vld = 1, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| alloc_vld | input | 1 | Advanced load records an entry this cycle |
| alloc_tag | input | TAG_W | Destination register tag of the advanced load |
| alloc_addr | input | ADDR_W | Byte address of the advanced load |
| st_vld | input | 1 | Store snoops the table this cycle |
| st_addr | input | ADDR_W | Byte address of the store |
| chk_vld | input | 1 | Check for a register this cycle |
| chk_tag | input | TAG_W | Register tag being checked |
| chk_clr | input | 1 | Remove the entry if the check succeeds |
| chk_resp_vld | output | 1 | Check response valid, one cycle after chk_vld |
| chk_redirect | output | 1 | Entry missing: branch to recovery code |

## Verification
Any wrong internal state in this block becomes visible at a check. A dropped valid bit, a stale granule, or a wrong age order turns into an unexpected redirect, or a missing one, on the first check of the affected tag. Because the response is registered, that error appears one cycle after the check is presented. The directed scenarios therefore follow every allocate and store pattern with checks on every tag involved, including the tags that should survive. This exposes a victim chosen wrongly or an invalidation that spread too far.

// File: rtl/slt_pkg.sv
package slt_pkg;
  localparam int SLT_ENTRIES = 16;
  localparam int SLT_TAG_W   = 7;
  localparam int SLT_ADDR_W  = 40;
  localparam int SLT_GRAN_LG = 3;

  // where an allocate lands
  typedef enum logic [1:0] {
    WAY_RETAG = 2'd0,
    WAY_FREE  = 2'd1,
    WAY_EVICT = 2'd2
  } way_src_e;
endpackage

// File: rtl/slt_cam.sv
module slt_cam #(
  parameter int N = 16,
  parameter int W = 8
) (
  input  logic [W-1:0]        key,
  input  logic [N-1:0]        live,
  input  logic [N-1:0][W-1:0] field,
  output logic [N-1:0]        hit
);
  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_cmp
      assign hit[g] = live[g] && (field[g] == key);
    end
  endgenerate
endmodule

// File: rtl/slt_age.sv
module slt_age #(
  parameter int N  = 16,
  parameter int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          touch,
  input  logic [IW-1:0] touch_idx,
  output logic [IW-1:0] victim_idx
);
  // older_q[i][j] = 1 : entry i was allocated before entry j
  logic [N-1:0][N-1:0] older_q, older_d;

  always_comb begin
    older_d = older_q;
    for (int i = 0; i < N; i++) begin
      older_d[touch_idx][i] = 1'b0;
      older_d[i][touch_idx] = (i != int'(touch_idx));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     older_q <= '0;
    else if (touch) older_q <= older_d;
  end

  // oldest entry: older than every other one
  always_comb begin
    logic [N-1:0] self_m;
    victim_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      self_m    = '0;
      self_m[i] = 1'b1;
      if (&(older_q[i] | self_m)) victim_idx = IW'(i);
    end
  end
endmodule

// File: rtl/slt_pick.sv
module slt_pick
  import slt_pkg::*;
#(
  parameter int N  = 16,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  retag_hit,
  input  logic [N-1:0]  free,
  input  logic [IW-1:0] victim_idx,
  output logic [IW-1:0] way_idx
);
  way_src_e     src;
  logic [IW-1:0] free_idx, retag_idx;

  always_comb begin
    free_idx  = '0;
    retag_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (free[i])      free_idx  = IW'(i);
      if (retag_hit[i]) retag_idx = IW'(i);
    end
    if (|retag_hit)  src = WAY_RETAG;
    else if (|free)  src = WAY_FREE;
    else             src = WAY_EVICT;
  end

  always_comb begin
    unique case (src)
      WAY_RETAG: way_idx = retag_idx;
      WAY_FREE:  way_idx = free_idx;
      default:   way_idx = victim_idx;
    endcase
  end
endmodule

// File: rtl/spec_load_table.sv
module spec_load_table
  import slt_pkg::*;
#(
  parameter int ENTRIES = SLT_ENTRIES,
  parameter int TAG_W   = SLT_TAG_W,
  parameter int ADDR_W  = SLT_ADDR_W,
  parameter int GRAN_LG = SLT_GRAN_LG
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_vld,
  input  logic [TAG_W-1:0]  alloc_tag,
  input  logic [ADDR_W-1:0] alloc_addr,
  input  logic              st_vld,
  input  logic [ADDR_W-1:0] st_addr,
  input  logic              chk_vld,
  input  logic [TAG_W-1:0]  chk_tag,
  input  logic              chk_clr,
  output logic              chk_resp_vld,
  output logic              chk_redirect
);
  localparam int IW = $clog2(ENTRIES);
  localparam int GW = ADDR_W - GRAN_LG;

  logic [ENTRIES-1:0]            vld_q, vld_a, vld_d;
  logic [ENTRIES-1:0][TAG_W-1:0] tag_q, tag_d;
  logic [ENTRIES-1:0][GW-1:0]    gran_q, gran_d;
  logic [ENTRIES-1:0]            retag_hit, chk_hit, st_hit;
  logic [IW-1:0]                 victim_idx, way_idx;
  logic [GW-1:0]                 alloc_gran, st_gran;
  logic                          table_en;
  logic                          resp_vld_d, redirect_d;

  assign alloc_gran = alloc_addr[ADDR_W-1:GRAN_LG];
  assign st_gran    = st_addr[ADDR_W-1:GRAN_LG];

  slt_cam #(.N(ENTRIES), .W(TAG_W)) u_alloc_cam (
    .key(alloc_tag), .live(vld_q), .field(tag_q), .hit(retag_hit)
  );

  slt_cam #(.N(ENTRIES), .W(TAG_W)) u_chk_cam (
    .key(chk_tag), .live(vld_q), .field(tag_q), .hit(chk_hit)
  );

  slt_age #(.N(ENTRIES), .IW(IW)) u_age (
    .clk(clk), .rst_n(rst_n), .touch(alloc_vld),
    .touch_idx(way_idx), .victim_idx(victim_idx)
  );

  slt_pick #(.N(ENTRIES), .IW(IW)) u_pick (
    .retag_hit(retag_hit), .free(~vld_q),
    .victim_idx(victim_idx), .way_idx(way_idx)
  );

  // step 1: clear on check, then allocate
  always_comb begin
    vld_a  = vld_q;
    tag_d  = tag_q;
    gran_d = gran_q;
    if (chk_vld && chk_clr) vld_a = vld_a & ~chk_hit;
    if (alloc_vld) begin
      vld_a[way_idx]  = 1'b1;
      tag_d[way_idx]  = alloc_tag;
      gran_d[way_idx] = alloc_gran;
    end
  end

  // step 2: store snoop applied to the post-allocate table
  slt_cam #(.N(ENTRIES), .W(GW)) u_st_cam (
    .key(st_gran), .live(vld_a), .field(gran_d), .hit(st_hit)
  );

  always_comb begin
    vld_d    = st_vld ? (vld_a & ~st_hit) : vld_a;
    table_en = alloc_vld | st_vld | (chk_vld & chk_clr);
  end

  always_comb begin
    resp_vld_d = chk_vld;
    redirect_d = chk_vld && !(|chk_hit);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        vld_q <= '0;
    else if (table_en) vld_q <= vld_d;
  end

  always_ff @(posedge clk) begin
    if (alloc_vld) begin
      tag_q  <= tag_d;
      gran_q <= gran_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chk_resp_vld <= 1'b0;
      chk_redirect <= 1'b0;
    end else begin
      chk_resp_vld <= resp_vld_d;
      chk_redirect <= redirect_d;
    end
  end
endmodule

// File: rtl/spec_load_table_chk.sv
module spec_load_table_chk #(
  parameter int TAG_W   = 7,
  parameter int ADDR_W  = 40,
  parameter int GRAN_LG = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              alloc_vld,
  input logic [TAG_W-1:0]  alloc_tag,
  input logic [ADDR_W-1:0] alloc_addr,
  input logic              st_vld,
  input logic [ADDR_W-1:0] st_addr,
  input logic              chk_vld,
  input logic [TAG_W-1:0]  chk_tag,
  input logic              chk_clr,
  input logic              chk_resp_vld,
  input logic              chk_redirect
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |-> (!chk_resp_vld && !chk_redirect));

  // R12
  resp_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chk_vld |=> chk_resp_vld);

  // R12
  resp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !chk_vld |=> !chk_resp_vld);

  // R11
  redirect_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chk_redirect |-> chk_resp_vld);

  // R2
  alloc_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_vld && !st_vld) ##1 (chk_vld && chk_tag == $past(alloc_tag))
    |=> !chk_redirect);

  // R9
  alloc_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_vld && st_vld &&
     alloc_addr[ADDR_W-1:GRAN_LG] == st_addr[ADDR_W-1:GRAN_LG])
    ##1 (chk_vld && chk_tag == $past(alloc_tag))
    |=> chk_redirect);

  // chk_clr is not covered by a property here
  logic unused_ok;
  assign unused_ok = chk_clr;
endmodule

bind spec_load_table spec_load_table_chk #(
  .TAG_W(TAG_W), .ADDR_W(ADDR_W), .GRAN_LG(GRAN_LG)
) u_chk (.*);

// File: tb/sim_spec_load_table.sv
`timescale 1ns/1ps
module sim_spec_load_table;
  localparam int TW = 7;
  localparam int AW = 40;

  logic          clk;
  logic          rst_n;
  logic          alloc_vld;
  logic [TW-1:0] alloc_tag;
  logic [AW-1:0] alloc_addr;
  logic          st_vld;
  logic [AW-1:0] st_addr;
  logic          chk_vld;
  logic [TW-1:0] chk_tag;
  logic          chk_clr;
  logic          chk_resp_vld;
  logic          chk_redirect;

  int n_chk  = 0;
  int n_fail = 0;

  spec_load_table u0 (
    .clk(clk), .rst_n(rst_n),
    .alloc_vld(alloc_vld), .alloc_tag(alloc_tag), .alloc_addr(alloc_addr),
    .st_vld(st_vld), .st_addr(st_addr),
    .chk_vld(chk_vld), .chk_tag(chk_tag), .chk_clr(chk_clr),
    .chk_resp_vld(chk_resp_vld), .chk_redirect(chk_redirect)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic expect2(input logic [1:0] act, input logic [1:0] exp, input string rq);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got {vld,redirect}=%b expected %b", rq, act, exp);
    end
  endtask

  task automatic summary();
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  task automatic idle_inputs();
    alloc_vld = 0; alloc_tag = '0; alloc_addr = '0;
    st_vld = 0; st_addr = '0;
    chk_vld = 0; chk_tag = '0; chk_clr = 0;
  endtask

  task automatic do_reset();
    idle_inputs();
    rst_n = 0;
    tick();
    expect2({chk_resp_vld, chk_redirect}, 2'b00, "R1 outputs in reset");
    tick();
    rst_n = 1;
  endtask

  task automatic alloc(input logic [TW-1:0] t, input logic [AW-1:0] a);
    alloc_vld = 1; alloc_tag = t; alloc_addr = a;
    tick();
    alloc_vld = 0;
  endtask

  task automatic store(input logic [AW-1:0] a);
    st_vld = 1; st_addr = a;
    tick();
    st_vld = 0;
  endtask

  task automatic chk(input logic [TW-1:0] t, input logic clr, input logic exp, input string rq);
    chk_vld = 1; chk_tag = t; chk_clr = clr;
    tick();
    chk_vld = 0; chk_clr = 0;
    expect2({chk_resp_vld, chk_redirect}, {1'b1, exp}, rq);
  endtask

  task automatic t_reset();
    do_reset();
    chk(7'd3, 0, 1, "R1 empty after reset");
    chk(7'd0, 0, 1, "R1 empty after reset tag0");
  endtask

  task automatic t_basic();
    do_reset();
    alloc(7'd5, 40'h1000);
    chk(7'd5, 0, 0, "R2 hit after allocate");
    chk(7'd6, 0, 1, "R2 miss for unknown tag");
    tick();
    expect2({chk_resp_vld, chk_redirect}, 2'b00, "R12 no response when idle");
  endtask

  task automatic t_store();
    do_reset();
    alloc(7'd1, 40'h200);
    alloc(7'd2, 40'h208);
    store(40'h20F);
    chk(7'd2, 0, 1, "R5 same granule upper byte removes");
    chk(7'd1, 0, 0, "R3 other granule untouched");
    store(40'h1FF);
    chk(7'd1, 0, 0, "R5 adjacent lower granule no conflict");
    store(40'h207);
    chk(7'd1, 0, 1, "R3 matching store removes entry");
  endtask

  task automatic t_multi();
    do_reset();
    alloc(7'd1, 40'h300);
    alloc(7'd2, 40'h304);
    alloc(7'd3, 40'h500);
    store(40'h302);
    chk(7'd1, 0, 1, "R4 first match removed");
    chk(7'd2, 0, 1, "R4 second match removed");
    chk(7'd3, 0, 0, "R4 non-match kept");
  endtask

  task automatic t_replace();
    do_reset();
    alloc(7'd4, 40'h400);
    alloc(7'd4, 40'h800);
    store(40'h400);
    chk(7'd4, 0, 0, "R6 old address no longer snooped");
    store(40'h800);
    chk(7'd4, 0, 1, "R6 new address snooped");
  endtask

  task automatic t_evict();
    do_reset();
    for (int i = 0; i < 16; i++) alloc(TW'(10 + i), 40'h1000 + AW'(8 * i));
    alloc(7'd10, 40'h2000);
    alloc(7'd30, 40'h2100);
    chk(7'd11, 0, 1, "R7 oldest allocate displaced");
    chk(7'd10, 0, 0, "R7 refreshed tag kept");
    chk(7'd30, 0, 0, "R7 new tag present");
    for (int i = 12; i < 26; i++) chk(TW'(i), 0, 0, "R7 other tags kept");
  endtask

  task automatic t_free();
    do_reset();
    for (int i = 0; i < 16; i++) alloc(TW'(40 + i), 40'h3000 + AW'(8 * i));
    store(40'h3028);
    chk(7'd45, 0, 1, "R8 store freed an entry");
    alloc(7'd60, 40'h4000);
    chk(7'd60, 0, 0, "R8 new tag in free entry");
    chk(7'd40, 0, 0, "R8 oldest not displaced");
    for (int i = 41; i < 56; i++)
      if (i != 45) chk(TW'(i), 0, 0, "R8 others kept");
  endtask

  task automatic t_same_cycle();
    do_reset();
    alloc(7'd9, 40'h900);
    alloc_vld = 1; alloc_tag = 7'd7; alloc_addr = 40'h700;
    st_vld = 1; st_addr = 40'h703;
    tick();
    alloc_vld = 0; st_vld = 0;
    chk(7'd7, 0, 1, "R9 same-cycle matching store wins");
    alloc_vld = 1; alloc_tag = 7'd8; alloc_addr = 40'h800;
    st_vld = 1; st_addr = 40'h900;
    tick();
    alloc_vld = 0; st_vld = 0;
    chk(7'd8, 0, 0, "R9 same-cycle other store keeps new");
    chk(7'd9, 0, 1, "R9 same-cycle store hits old entry");
  endtask

  task automatic t_clear();
    do_reset();
    alloc(7'd12, 40'hC00);
    chk(7'd12, 1, 0, "R10 clearing check succeeds");
    chk(7'd12, 0, 1, "R10 entry gone after clear");
    alloc(7'd13, 40'hD00);
    chk(7'd13, 0, 0, "R10 non-clearing check");
    chk(7'd13, 0, 0, "R10 entry kept");
  endtask

  task automatic t_order();
    do_reset();
    alloc(7'd14, 40'hE00);
    chk_vld = 1; chk_tag = 7'd14; st_vld = 1; st_addr = 40'hE00;
    tick();
    chk_vld = 0; st_vld = 0;
    expect2({chk_resp_vld, chk_redirect}, 2'b10, "R11 check sees table before store");
    chk(7'd14, 0, 1, "R11 store visible next check");
    chk_vld = 1; chk_tag = 7'd15; alloc_vld = 1; alloc_tag = 7'd15; alloc_addr = 40'hF00;
    tick();
    chk_vld = 0; alloc_vld = 0;
    expect2({chk_resp_vld, chk_redirect}, 2'b11, "R11 check sees table before allocate");
    chk(7'd15, 0, 0, "R11 allocate visible next check");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    idle_inputs();
    rst_n = 0;
    t_reset();
    t_basic();
    t_store();
    t_multi();
    t_replace();
    t_evict();
    t_free();
    t_same_cycle();
    t_clear();
    t_order();
    tick();
    summary();
    $finish;
  end
endmodule